// File: doc/BRIEF.md
# Dual-Channel Serial DAC Register Front End

This block is the digital side of a two-channel voltage DAC. A serial slave receives 16-bit command words on an SPI-style link that is select-qualified and sampled on the rising clock edge, with the most significant bit first. It accepts either clock polarity convention (idle low or idle high). The serial clock, select, data and latch inputs are all asynchronous to the system clock. Each is brought through a synchronizer with edge detection before any logic uses it.

A committed word updates the staging register of the channel it addresses. A staging register holds a data code, a gain choice and an active/shutdown choice. The channel outputs come from a second register per channel. While the active-low latch input is asserted, both second registers copy their staging registers in the same cycle. If the latch input is tied low, the outputs follow each write soon after the select line returns high. The outputs are the latched code, a unity-gain flag and a high-impedance (shutdown) flag for each channel.

Top module: `dual_dac_ctrl`

## Requirements
- R1: While `spi_cs_n` is high, clock edges and data on `spi_sck`/`spi_mosi` change no register and commit nothing.
- R2: Bits are sampled on rising `spi_sck` edges, MSB first, with the clock idling either low or high between frames.
- R3: Word bit 15 picks the channel (0 = A, 1 = B). The other channel's staging register is left unchanged.
- R4: While `latch_n` is high, a committed write does not change any output.
- R5: While `latch_n` is low, both output registers load from their staging registers in the same system clock cycle.
- R6: With `latch_n` held low, the outputs show a new word only after `spi_cs_n` rises at the end of its frame.
- R7: Word bit 13 set gives unity gain (`unity` = 1) and clear gives 2x gain. Word bit 12 clear puts the channel in shutdown (`hiz` = 1). Bit 14 has no effect.
- R8: Bits 11:0 carry the code left-justified: a DATA_W-bit code is taken from bits 11 down to 12-DATA_W, and the lower bits are ignored.
- R9: A frame commits only if exactly 16 rising clock edges occur while select is low. Frames with 15 or 17 edges are discarded.
- R10: Reset clears both channels to code 0 with 2x gain, in shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, asynchronous |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data in |
| latch_n | input | 1 | Active-low transfer strobe for both channels |
| code_a | output | DATA_W | Latched code, channel A |
| unity_a | output | 1 | Channel A gain is 1x when high |
| hiz_a | output | 1 | Channel A in shutdown |
| code_b | output | DATA_W | Latched code, channel B |
| unity_b | output | 1 | Channel B gain is 1x when high |
| hiz_b | output | 1 | Channel B in shutdown |

## Verification
A wrong bit count or a bad shift order leaves a staging register wrong without any visible effect until the next transfer. For that reason every write is followed by a latch pulse, and both channels are compared a few cycles after the synchronizer delay. A misrouted write shows on the wrong channel at that transfer. A transfer that is not simultaneous shows as a single cycle where one channel has moved and the other has not, so the outputs are polled every cycle while the strobe takes effect.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int WORD_W  = 16;
  localparam int FIELD_W = 12;

  function automatic logic word_channel(input logic [WORD_W-1:0] w);
    return w[15];
  endfunction

  function automatic logic word_unity(input logic [WORD_W-1:0] w);
    return w[13];
  endfunction

  function automatic logic word_active(input logic [WORD_W-1:0] w);
    return w[12];
  endfunction

  function automatic logic [FIELD_W-1:0] word_field(input logic [WORD_W-1:0] w);
    return w[FIELD_W-1:0];
  endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else if (s == 0) stage_q[s] <= async_i;
        else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else prev_q <= stage_q[STAGES-1];
  end

  assign level_o = stage_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_low,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              mosi,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int SAT   = WORD_W + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              take_bit;

  assign take_bit = cs_low && sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
    end else if (take_bit) begin
      shift_q <= {shift_q[WORD_W-2:0], mosi};
      if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o   = shift_q;
  assign commit_o = cs_rise && (cnt_q == CNT_W'(WORD_W));

  assert_ignore_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_low && sck_rise) |=> $stable(shift_q));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SAT));
  assert_single_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
endmodule

// File: rtl/dacfe_regbank.sv
module dacfe_regbank
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              load,
  output logic [DATA_W-1:0] code_o  [2],
  output logic              unity_o [2],
  output logic              hiz_o   [2]
);
  localparam int NCH = 2;
  localparam int LSB = FIELD_W - DATA_W;

  typedef struct packed {
    logic              unity;
    logic              active;
    logic [DATA_W-1:0] code;
  } chan_t;

  chan_t stage_q [NCH];
  chan_t out_q   [NCH];
  chan_t wr_val;
  logic [FIELD_W-1:0] field;

  assign field  = word_field(wr_word);
  assign wr_val = '{unity: word_unity(wr_word), active: word_active(wr_word),
                    code: field[FIELD_W-1:LSB]};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel = wr_en && (word_channel(wr_word) == 1'(c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[c] <= '0;
        else if (sel) stage_q[c] <= wr_val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q[c] <= '0;
        else if (load) out_q[c] <= stage_q[c];
      end

      assign code_o[c]  = out_q[c].code;
      assign unity_o[c] = out_q[c].unity;
      assign hiz_o[c]   = !out_q[c].active;

      assert_hold_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(out_q[c]));
      assert_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && word_channel(wr_word) != 1'(c)) |=> $stable(stage_q[c]));
    end
  endgenerate

  assert_joint_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_q[0] == $past(stage_q[0])) && (out_q[1] == $past(stage_q[1])));
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dacfe_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              latch_n,
  output logic [DATA_W-1:0] code_a,
  output logic              unity_a,
  output logic              hiz_a,
  output logic [DATA_W-1:0] code_b,
  output logic              unity_b,
  output logic              hiz_b
);
  localparam int NSIG = 4;
  localparam logic [NSIG-1:0] IDLE = 4'b1100;

  logic [NSIG-1:0] lvl, rise, fall;
  logic [WORD_W-1:0] frame_word;
  logic frame_commit;
  logic [DATA_W-1:0] code_v [2];
  logic unity_v [2];
  logic hiz_v [2];

  dacfe_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({latch_n, spi_cs_n, spi_sck, spi_mosi}),
    .level_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  dacfe_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_rise(rise[1]), .cs_low(!lvl[2]), .cs_fall(fall[2]), .cs_rise(rise[2]),
    .mosi(lvl[0]), .word_o(frame_word), .commit_o(frame_commit)
  );

  dacfe_regbank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(frame_commit), .wr_word(frame_word), .load(!lvl[3]),
    .code_o(code_v), .unity_o(unity_v), .hiz_o(hiz_v)
  );

  assign code_a  = code_v[0];
  assign unity_a = unity_v[0];
  assign hiz_a   = hiz_v[0];
  assign code_b  = code_v[1];
  assign unity_b = unity_v[1];
  assign hiz_b   = hiz_v[1];

  assert_commit_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |-> lvl[2]);
endmodule

// File: tb/dual_dac_ctrl_bench.sv
module dual_dac_ctrl_bench;
  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, mosi = 0, latch_n = 1;
  logic [11:0] code_a, code_b;
  logic [7:0]  n_code_a, n_code_b;
  logic unity_a, hiz_a, unity_b, hiz_b, n_unity_a, n_hiz_a, n_unity_b, n_hiz_b;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [13:0] exp_in [2];
  logic [13:0] exp_out [2];
  localparam int H = 4;

  always #2 clk = ~clk;

  dual_dac_ctrl u_dual_dac_ctrl (.clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .latch_n(latch_n), .code_a(code_a), .unity_a(unity_a), .hiz_a(hiz_a),
    .code_b(code_b), .unity_b(unity_b), .hiz_b(hiz_b));

  dual_dac_ctrl #(.DATA_W(8)) u_narrow (.clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .latch_n(latch_n), .code_a(n_code_a), .unity_a(n_unity_a), .hiz_a(n_hiz_a),
    .code_b(n_code_b), .unity_b(n_unity_b), .hiz_b(n_hiz_b));

  function automatic logic [13:0] view(input logic [15:0] w);
    return {~w[12], w[13], w[11:0]};
  endfunction

  function automatic logic [13:0] seen(input int c);
    return (c == 0) ? {hiz_a, unity_a, code_a} : {hiz_b, unity_b, code_b};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit m11);
    sck = m11; wclk(H);
    cs_n = 0; wclk(H);
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 16) ? w[15-i] : 1'b0;
      if (m11) begin
        sck = 0; mosi = b; wclk(H); sck = 1; wclk(H);
      end else begin
        mosi = b; wclk(H); sck = 1; wclk(H); sck = 0;
      end
    end
    wclk(H);
    cs_n = 1; wclk(8);
    sck = 0; wclk(H);
    if (nbits == 16) exp_in[w[15]] = view(w);
  endtask

  task automatic pulse_latch;
    latch_n = 0; wclk(4);
    latch_n = 1; wclk(8);
    exp_out[0] = exp_in[0];
    exp_out[1] = exp_in[1];
  endtask

  task automatic check_outs(input string req);
    chk(req, {18'd0, seen(0)}, {18'd0, exp_out[0]});
    chk(req, {18'd0, seen(1)}, {18'd0, exp_out[1]});
    chk({req, " R8 narrow"}, {n_hiz_a, n_unity_a, n_code_a, n_hiz_b, n_unity_b, n_code_b},
        {exp_out[0][13:12], exp_out[0][11:4], exp_out[1][13:12], exp_out[1][11:4]});
  endtask

  task automatic do_reset;
    rst_n = 0; wclk(3); rst_n = 1; wclk(3);
    for (int c = 0; c < 2; c++) begin
      exp_in[c] = 14'h2000; exp_out[c] = 14'h2000;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_outs("R10 reset");

    // R2 R3 R7 R4: sweep headers, codes, both clock polarities
    for (int m = 0; m < 2; m++)
      for (int hdr = 0; hdr < 16; hdr++)
        for (int k = 0; k < 4; k++) begin
          logic [11:0] code;
          logic [15:0] w;
          code = (k == 0) ? 12'hFFF : (k == 1) ? 12'h000 : 12'((k * 2477) ^ (hdr * 273) ^ (m * 1365));
          w = {4'(hdr), code};
          send(w, 16, m[0]);
          chk("R4 hold", {18'd0, seen(0), seen(1)} , {18'd0, exp_out[0], exp_out[1]});
          pulse_latch();
          check_outs("R2 R3 R7");
        end

    // R9: 15 and 17 edge frames discarded
    send(16'h3ABC, 15, 0); pulse_latch(); check_outs("R9 short");
    send(16'hB123, 17, 1); pulse_latch(); check_outs("R9 long");
    send(16'hB123, 16, 1); pulse_latch(); check_outs("R9 exact");

    // R1: edges with select high
    for (int i = 0; i < 16; i++) begin
      mosi = i[0]; wclk(H); sck = 1; wclk(H); sck = 0;
    end
    pulse_latch(); check_outs("R1 idle");

    // R5: both channels move in the same cycle
    send(16'h1111, 16, 0); send(16'h9EEE, 16, 0);
    begin
      logic [13:0] oa, ob;
      bit seen_chg;
      oa = seen(0); ob = seen(1); seen_chg = 0;
      latch_n = 0;
      for (int i = 0; i < 20 && !seen_chg; i++) begin
        wclk(1);
        if (seen(0) != oa || seen(1) != ob) begin
          seen_chg = 1;
          chk("R5 joint", {4'd0, seen(0), seen(1)}, {4'd0, exp_in[0], exp_in[1]});
        end
      end
      chk("R5 moved", 32'(seen_chg), 32'd1);
      latch_n = 1; wclk(8);
      exp_out[0] = exp_in[0]; exp_out[1] = exp_in[1];
    end

    // R6: latch held low, update only after select rises
    latch_n = 0; wclk(8);
    begin
      logic [15:0] w;
      w = 16'h3456;
      sck = 0; cs_n = 0; wclk(H);
      for (int i = 0; i < 16; i++) begin
        mosi = w[15-i]; wclk(H); sck = 1; wclk(H); sck = 0;
      end
      wclk(H);
      chk("R6 before release", {18'd0, seen(0)}, {18'd0, exp_out[0]});
      cs_n = 1; wclk(8);
      exp_in[0] = view(w); exp_out[0] = exp_in[0];
      chk("R6 after release", {18'd0, seen(0)}, {18'd0, exp_out[0]});
    end
    latch_n = 1; wclk(4);

    do_reset();
    check_outs("R10 second reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule